// File: doc/BRIEF.md
# Token-Passing Row Hit Sparsifier

This block reads out one row of digitized pixels and puts only the hit pixels on a shared row bus. Each cell holds a small ADC code. A code of zero means the pixel saw nothing. An inject pulse takes a snapshot of every cell's code and launches a single token at cell 0.

The token moves through empty cells within the same token-clock cycle. When it reaches a cell with a hit, that cell holds the token for one cycle. During that cycle the cell places its column address and its code on the bus and clears its own pending code. In the next cycle it hands the token on. When the token leaves the last cell, a sticky token-returned flag rises.

The bus outputs are registered, so each served cell shows up on the bus one clock edge after it holds the token. A downstream row buffer can shift in one entry per valid beat and use the token-returned flag to tell that the row is finished.

Top module: `row_token_sparsifier`

## Requirements
- R1: After reset, or whenever reset is asserted, bus_valid_o, bus_addr_o, bus_code_o and tok_done_o are all 0, and no stale token remains in the row. Reset is synchronous and active high.
- R2: The inject pulse captures codes_i. Cell i uses bits [3*i+2 : 3*i]. A captured code of 3'b000 is not a hit, and any nonzero code is a hit.
- R3: The cell served in the inject cycle appears on the bus after the inject edge. Each further hit appears on the following edges, one per clock, in strictly ascending address order, with no idle beats between hits.
- R4: While bus_valid_o is 1, bus_addr_o holds the served cell's index as an unsigned binary number and bus_code_o holds that cell's captured 3-bit code.
- R5: Each hit cell is put on the bus exactly once per scan, including when every cell in the row is a hit.
- R6: tok_done_o rises on the edge after the last hit beat. It stays 1, with bus_valid_o at 0, until the next inject. An inject that finds at least one hit clears it.
- R7: If the captured row has no hit, tok_done_o is 1 right after the inject edge and bus_valid_o never rises.
- R8: Changes on codes_i after the inject cycle have no effect on the scan in progress.
- R9: An inject during a scan abandons the old token and its pending codes, and restarts the scan at cell 0 with the new snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Token clock |
| rst | input | 1 | Synchronous reset, active high |
| inject_i | input | 1 | Snapshot the codes and launch the token at cell 0 |
| codes_i | input | 1536 | Per-cell 3-bit codes, cell i at bits [3*i+2:3*i] |
| bus_valid_o | output | 1 | Row bus carries a served hit this cycle |
| bus_addr_o | output | 9 | Address of the served cell |
| bus_code_o | output | 3 | Captured code of the served cell |
| tok_done_o | output | 1 | Token has left the last cell (sticky until inject) |

## Verification
The scan is driven with a set of row patterns, each aimed at a different risk:
- An empty row separates the same-cycle token return from a stalled token.
- Single hits at cell 0 and cell 511 test the two ends of the chain, the release from the last cell, and the hand-off from the injected token.
- Adjacent hits, and hits listed out of address order, show whether the token stalls and releases correctly and whether the output is in ascending order.
- A zero code placed among hits must be skipped.
- A fully populated row shows whether every cell is served exactly once.

Directed runs cover three cases: changing the codes after inject, injecting again mid-scan, and asserting reset mid-scan. Each one shows whether stale tokens or stale codes survive.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int DEF_CELLS  = 512;
  localparam int DEF_CODE_W = 3;

  // Next value of the sticky token-returned flag.
  function automatic logic done_next(input logic done_q, input logic inj, input logic tail);
    if (inj) return tail;
    return done_q | tail;
  endfunction

  // A captured code counts as a hit when any bit is set (zero-extended input).
  function automatic logic code_hit(input logic [7:0] c);
    return c != 8'd0;
  endfunction
endpackage

// File: rtl/rsp_cell.sv
module rsp_cell
  import rsp_pkg::*;
#(
  parameter int CODE_W = DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inject_i,
  input  logic              tok_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tok_o,
  output logic              en_o,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] held_q;
  logic [CODE_W-1:0] live;
  logic              rel_q;

  // During inject the fresh snapshot is used directly.
  assign live   = inject_i ? code_i : held_q;
  assign hit_o  = code_hit(8'(live));
  assign en_o   = tok_i & hit_o;
  assign code_o = en_o ? live : '0;
  // Empty cell passes token at once; a served cell releases it one cycle later.
  assign tok_o  = (tok_i & ~hit_o) | (rel_q & ~inject_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      rel_q  <= 1'b0;
    end else begin
      rel_q <= en_o;
      if (en_o)          held_q <= '0;
      else if (inject_i) held_q <= code_i;
    end
  end

  // R5: a served cell is never pending again in the same scan
  a_r5_served_once: assert property (@(posedge clk) disable iff (rst)
    en_o |=> (inject_i || !hit_o));
endmodule

// File: rtl/rsp_bus_reg.sv
module rsp_bus_reg #(
  parameter int CELLS  = 512,
  parameter int CODE_W = 3,
  localparam int ADDR_W = $clog2(CELLS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CELLS-1:0]        en_i,
  input  logic [CELLS*CODE_W-1:0] code_i,
  output logic                    valid_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [CODE_W-1:0]       code_o
);
  logic              any_en;
  logic [ADDR_W-1:0] addr_c;
  logic [CODE_W-1:0] code_c;

  // Wired-OR row bus: at most one enable is active.
  always_comb begin
    addr_c = '0;
    code_c = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (en_i[i]) addr_c = addr_c | ADDR_W'(i);
      code_c = code_c | code_i[i*CODE_W +: CODE_W];
    end
  end
  assign any_en = |en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      code_o  <= '0;
    end else begin
      valid_o <= any_en;
      addr_o  <= any_en ? addr_c : '0;
      code_o  <= code_c;
    end
  end

  // R3: only one cell may drive the bus per token clock
  a_r3_single_driver: assert property (@(posedge clk) disable iff (rst) $onehot0(en_i));
  // R4: bus code is nonzero exactly on valid beats
  a_r4_code_on_valid: assert property (@(posedge clk) disable iff (rst)
    valid_o == (code_o != '0));
endmodule

// File: rtl/row_token_sparsifier.sv
module row_token_sparsifier
  import rsp_pkg::*;
#(
  parameter int CELLS  = DEF_CELLS,
  parameter int CODE_W = DEF_CODE_W,
  localparam int ADDR_W = $clog2(CELLS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inject_i,
  input  logic [CELLS*CODE_W-1:0] codes_i,
  output logic                    bus_valid_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [CODE_W-1:0]       bus_code_o,
  output logic                    tok_done_o
);
  logic [CELLS-1:0]        en_vec;
  logic [CELLS-1:0]        hit_vec;
  logic [CELLS*CODE_W-1:0] drv_codes;
  logic                    tok_tail;   // token leaving last cell
  logic                    row_has_hit;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic t_in;
    logic t_out;
    if (i == 0) begin : g_head
      assign t_in = inject_i;
    end else begin : g_link
      assign t_in = g_cell[i-1].t_out;
    end
    rsp_cell #(.CODE_W(CODE_W)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .inject_i(inject_i),
      .tok_i   (t_in),
      .code_i  (codes_i[i*CODE_W +: CODE_W]),
      .tok_o   (t_out),
      .en_o    (en_vec[i]),
      .hit_o   (hit_vec[i]),
      .code_o  (drv_codes[i*CODE_W +: CODE_W])
    );
  end
  assign tok_tail    = g_cell[CELLS-1].t_out;
  assign row_has_hit = |hit_vec;

  rsp_bus_reg #(.CELLS(CELLS), .CODE_W(CODE_W)) u_bus (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_vec),
    .code_i (drv_codes),
    .valid_o(bus_valid_o),
    .addr_o (bus_addr_o),
    .code_o (bus_code_o)
  );

  always_ff @(posedge clk) begin
    if (rst) tok_done_o <= 1'b0;
    else     tok_done_o <= done_next(tok_done_o, inject_i, tok_tail);
  end

  // R6: returned flag is sticky until inject
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (tok_done_o && !inject_i) |=> tok_done_o);
  // R6: no bus traffic once the token is back
  a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    (tok_done_o && !inject_i) |=> !bus_valid_o);
  // R7: an empty snapshot returns the token in the inject cycle
  a_r7_empty_row: assert property (@(posedge clk) disable iff (rst)
    (inject_i && !row_has_hit) |=> (tok_done_o && !bus_valid_o));
  // R3: consecutive beats of one scan climb in address
  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && $past(bus_valid_o) && !$past(inject_i)) |-> (bus_addr_o > $past(bus_addr_o)));
endmodule

// File: tb/sim_row_token_sparsifier.sv
module sim_row_token_sparsifier;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 512;
  localparam int CW = 3;

  // {pos2,code2,pos1,code1,pos0,code0}; code 0 leaves the slot unused
  localparam logic [35:0] VEC [8] = '{
    36'd0,
    {24'd0, 9'd0, 3'd7},
    {24'd0, 9'd511, 3'd1},
    {12'd0, 9'd6, 3'd4, 9'd5, 3'd3},
    {9'd200, 3'd2, 9'd10, 3'd6, 9'd300, 3'd5},
    {9'd511, 3'd3, 9'd1, 3'd1, 9'd0, 3'd2},
    {9'd7, 3'd5, 9'd101, 3'd0, 9'd100, 3'd2},
    {9'd258, 3'd7, 9'd257, 3'd6, 9'd256, 3'd5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inject = 1'b0;
  logic [N*CW-1:0] codes = '0;
  logic bus_valid, tok_done;
  logic [8:0] bus_addr;
  logic [2:0] bus_code;

  int n_chk = 0;
  int n_bad = 0;
  int exp_addr [N];
  logic [2:0] exp_code [N];
  int exp_cnt;

  row_token_sparsifier u0 (
    .clk(clk), .rst(rst), .inject_i(inject), .codes_i(codes),
    .bus_valid_o(bus_valid), .bus_addr_o(bus_addr), .bus_code_o(bus_code),
    .tok_done_o(tok_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [N*CW-1:0] build(input logic [35:0] v);
    logic [N*CW-1:0] cv = '0;
    for (int k = 0; k < 3; k++) begin
      logic [2:0] c = v[k*12 +: 3];
      int p = int'(v[k*12+3 +: 9]);
      if (c != 3'd0) cv[p*CW +: CW] = c;
    end
    return cv;
  endfunction

  // Expected beats: nonzero codes taken in ascending index order
  task automatic expect_from(input logic [N*CW-1:0] cv);
    exp_cnt = 0;
    for (int i = 0; i < N; i++)
      if (cv[i*CW +: CW] != 3'd0) begin
        exp_addr[exp_cnt] = i;
        exp_code[exp_cnt] = cv[i*CW +: CW];
        exp_cnt++;
      end
  endtask

  task automatic run_scan(input logic [N*CW-1:0] cv, input logic [N*CW-1:0] after_cv);
    expect_from(cv);
    @(negedge clk); codes = cv; inject = 1'b1;
    @(negedge clk); inject = 1'b0; codes = after_cv;
    for (int k = 0; k < exp_cnt; k++) begin
      chk("R3 valid beat", int'(bus_valid), 1);
      chk("R4 address", int'(bus_addr), exp_addr[k]);
      chk("R4 code", int'(bus_code), int'(exp_code[k]));
      chk("R6 done low during scan", int'(tok_done), 0);
      @(negedge clk);
    end
    chk(exp_cnt == 0 ? "R7 empty row done" : "R6 done after last", int'(tok_done), 1);
    chk("R5 no extra beat", int'(bus_valid), 0);
    @(negedge clk);
    chk("R6 done sticky", int'(tok_done), 1);
    chk("R6 quiet after done", int'(bus_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [N*CW-1:0] full;
    logic [N*CW-1:0] fives;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 valid", int'(bus_valid), 0);
    chk("R1 done", int'(tok_done), 0);
    chk("R1 addr", int'(bus_addr), 0);
    chk("R1 code", int'(bus_code), 0);

    // Table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < 8; v++) run_scan(build(VEC[v]), build(VEC[v]));

    // R5: every cell hit
    for (int i = 0; i < N; i++) full[i*CW +: CW] = 3'(i % 7 + 1);
    run_scan(full, full);

    // R8: codes changed after inject are ignored
    for (int i = 0; i < N; i++) fives[i*CW +: CW] = 3'd5;
    run_scan(build({12'd0, 9'd9, 3'd6, 9'd3, 3'd2}), fives);

    // R9: reinject mid-scan restarts from cell 0
    @(negedge clk); codes = build({9'd70, 3'd1, 9'd60, 3'd1, 9'd50, 3'd1}); inject = 1'b1;
    @(negedge clk); inject = 1'b0;
    chk("R9 first beat of old scan", int'(bus_addr), 50);
    codes = build({24'd0, 9'd20, 3'd4}); inject = 1'b1;
    @(negedge clk); inject = 1'b0;
    chk("R9 restart valid", int'(bus_valid), 1);
    chk("R9 restart addr", int'(bus_addr), 20);
    chk("R9 restart code", int'(bus_code), 4);
    @(negedge clk);
    chk("R9 old token gone", int'(bus_valid), 0);
    chk("R9 done after restart", int'(tok_done), 1);
    @(negedge clk);
    chk("R9 no stale hits", int'(bus_valid), 0);

    // R1: reset in the middle of a full scan
    @(negedge clk); codes = full; inject = 1'b1;
    @(negedge clk); inject = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid-scan valid", int'(bus_valid), 0);
    chk("R1 mid-scan done", int'(tok_done), 0);
    @(negedge clk);
    chk("R1 no stale token", int'(bus_valid), 0);
    chk("R1 done stays low", int'(tok_done), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule